// File: doc/BRIEF.md
# GPIO Bank with Masked Output Writes

This block is a 32-pin general-purpose I/O bank on a plain 32-bit register bus. A combinational read port and a single-cycle write strobe are its only bus interface. Per pin it keeps an output value, a direction bit and an output-enable bit. It drives the output values and a tri-state enable for each pad, and it samples the pad inputs through a two-stage synchronizer.

Software can set the output value in two ways. It can write the whole word at once. It can also write one of two half-word ports, each of which changes only a chosen subset of 16 output bits. The upper 16 bits of a half-word write are a write-protect mask and the lower 16 bits are the new values. This lets one write change selected pins without first reading the register. A separate read-only offset returns the synchronized pad levels.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, the output value, direction and output-enable registers are all 0. `pin_out` and `pin_oe` are 0, and reads of offsets 0x040, 0x204 and 0x208 return 0.
- R2: A write to offset 0x000 uses `bus_wdata[31:16]` as a mask and `bus_wdata[15:0]` as data. Output bit i (i = 0..15) takes data bit i when mask bit 16+i is 0 and keeps its old value when that mask bit is 1. Output bits 31:16 do not change.
- R3: A write to offset 0x004 uses the same layout. Data bit i goes to output bit 16+i when mask bit 16+i is 0, and the bit keeps its old value when that mask bit is 1. Output bits 15:0 do not change.
- R4: Offset 0x040 is the whole output value register, read/write. A write replaces all 32 bits and a read returns them. With no write to 0x000, 0x004 or 0x040, the value does not change.
- R5: Offset 0x204 is the direction register, read/write, where 1 means output. Offset 0x208 is the output-enable register, read/write. Each keeps its value unless its own offset is written.
- R6: `pin_oe[i]` is 1 only when both direction bit i and output-enable bit i are 1.
- R7: A read of offset 0x060 returns `pin_in` as sampled two rising clock edges earlier. A change of `pin_in` is not visible after one edge and is visible after the second. Writes to 0x060 change no register.
- R8: Reads of the write-only offsets 0x000 and 0x004, and of any unmapped offset, return 0. Writes to unmapped offsets change no register.
- R9: `pin_out` always equals the output value register, as read at 0x040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous to `clk` |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Tri-state enable per pin, 1 = drive |

## Verification
The assertions check every cycle that a half-word write leaves the other half untouched and leaves its masked bits alone. They also check that the registers hold when no write targets them, that write-only and unmapped offsets read as zero, that at most one offset decodes at a time, and that the live-value path has exactly two cycles of latency. Only the bench scenarios can show that the mask and data bits of a write land at the right positions with the right values. The same holds for the OR-free combination of direction and output enable at the pads, and for the ordering of the synchronizer edges. The bench checks these against hand-computed words.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  parameter int ADDR_W = 12;

  // Register offsets (software decodes these; keep them fixed)
  localparam logic [ADDR_W-1:0] OFS_MASK_LO = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_VALUE   = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_LIVE    = 12'h060;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 12'h204;
  localparam logic [ADDR_W-1:0] OFS_DRIVE   = 12'h208;

  typedef struct packed {
    logic mask_lo;
    logic mask_hi;
    logic value;
    logic live;
    logic dir;
    logic drive;
  } bank_sel_t;

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output bank_sel_t         sel,
  output logic              sel_none
);

  always_comb begin
    sel         = '0;
    sel.mask_lo = (addr == OFS_MASK_LO);
    sel.mask_hi = (addr == OFS_MASK_HI);
    sel.value   = (addr == OFS_VALUE);
    sel.live    = (addr == OFS_LIVE);
    sel.dir     = (addr == OFS_DIR);
    sel.drive   = (addr == OFS_DRIVE);
  end

  assign sel_none = (sel == '0);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R8

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] d_async,
  output logic [PIN_W-1:0] d_sync
);

  logic [PIN_W-1:0] stage1_q;
  logic [PIN_W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;

  // cycles since reset, saturating at 2, only to arm the latency check
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (d_sync == $past(d_async, 2))); // R7

endmodule

// File: rtl/gpio_bank_outreg.sv
module gpio_bank_outreg #(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_full,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] value_q
);

  localparam int HALF     = PIN_W / 2;
  localparam int NUM_HALF = 2;

  // mask bit 1 protects the old bit, mask bit 0 lets data through
  function automatic logic [HALF-1:0] merge_masked(
    input logic [HALF-1:0] old_bits,
    input logic [HALF-1:0] protect,
    input logic [HALF-1:0] new_bits
  );
    return (old_bits & protect) | (new_bits & ~protect);
  endfunction

  logic [HALF-1:0] wr_protect;
  logic [HALF-1:0] wr_bits;
  assign wr_protect = wdata[PIN_W-1:HALF];
  assign wr_bits    = wdata[HALF-1:0];

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic            half_wr;
    logic [HALF-1:0] half_q;
    assign half_wr = (h == 0) ? wr_lo : wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        half_q <= '0;
      else if (wr_full)
        half_q <= wdata[h*HALF +: HALF];
      else if (half_wr)
        half_q <= merge_masked(half_q, wr_protect, wr_bits);
    end

    assign value_q[h*HALF +: HALF] = half_q;
  end

  AST_LO_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> value_q[PIN_W-1:HALF] == $past(value_q[PIN_W-1:HALF])); // R2
  AST_LO_PROTECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (value_q[HALF-1:0] & $past(wr_protect)) ==
              ($past(value_q[HALF-1:0]) & $past(wr_protect))); // R2
  AST_HI_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> value_q[HALF-1:0] == $past(value_q[HALF-1:0])); // R3
  AST_HI_PROTECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (value_q[PIN_W-1:HALF] & $past(wr_protect)) ==
              ($past(value_q[PIN_W-1:HALF]) & $past(wr_protect))); // R3
  AST_VALUE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi || wr_full) |=> $stable(value_q)); // R4

endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe
);

  bank_sel_t        sel;
  logic             sel_none;
  logic             wr_lo, wr_hi, wr_full, wr_dir, wr_drive;
  logic [PIN_W-1:0] value_q;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] drive_q;
  logic [PIN_W-1:0] live_sync;

  gpio_bank_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .sel      (sel),
    .sel_none (sel_none)
  );

  assign wr_lo    = bus_we & sel.mask_lo;
  assign wr_hi    = bus_we & sel.mask_hi;
  assign wr_full  = bus_we & sel.value;
  assign wr_dir   = bus_we & sel.dir;
  assign wr_drive = bus_we & sel.drive;

  gpio_bank_outreg #(.PIN_W(PIN_W)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_full (wr_full),
    .wdata   (bus_wdata),
    .value_q (value_q)
  );

  gpio_bank_sync #(.PIN_W(PIN_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .d_sync  (live_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      drive_q <= '0;
    end else begin
      if (wr_dir)   dir_q   <= bus_wdata;
      if (wr_drive) drive_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel.value) bus_rdata = value_q;
    if (sel.live)  bus_rdata = live_sync;
    if (sel.dir)   bus_rdata = dir_q;
    if (sel.drive) bus_rdata = drive_q;
  end

  assign pin_out = value_q;
  assign pin_oe  = dir_q & drive_q;

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q)); // R5
  AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_drive |=> $stable(drive_q)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |-> bus_rdata == '0); // R8
  AST_WRITE_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.mask_lo || sel.mask_hi) |-> bus_rdata == '0); // R8
  AST_PADS_FOLLOW_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    sel.value |-> bus_rdata == pin_out); // R9

endmodule

// File: tb/test_gpio_mask_bank.sv
module test_gpio_mask_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mask_bank i_gpio_mask_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {addr, wdata, expected output value afterwards}
  localparam int NVEC = 9;
  localparam logic [75:0] VEC [NVEC] = '{
    {12'h040, 32'hA5A5_5A5A, 32'hA5A5_5A5A}, // R4 full word
    {12'h000, 32'hFF00_1234, 32'hA5A5_5A34}, // R2 low byte only
    {12'h004, 32'h0000_BEEF, 32'hBEEF_5A34}, // R3 no protection
    {12'h004, 32'hFFFF_0000, 32'hBEEF_5A34}, // R3 all protected
    {12'h000, 32'h0F0F_FFFF, 32'hBEEF_FAF4}, // R2 interleaved mask
    {12'h004, 32'hAAAA_0000, 32'hAAAA_FAF4}, // R3 clear unprotected
    {12'h060, 32'hFFFF_FFFF, 32'hAAAA_FAF4}, // R7 live offset ignores write
    {12'h3FC, 32'h0000_0000, 32'hAAAA_FAF4}, // R8 unmapped ignores write
    {12'h204, 32'h1234_5678, 32'hAAAA_FAF4}  // R5 direction leaves value
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    bus_read(12'h040, rd); check("R1 value", rd, 32'h0);
    bus_read(12'h204, rd); check("R1 dir", rd, 32'h0);
    bus_read(12'h208, rd); check("R1 drive", rd, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      bus_write(VEC[v][75:64], VEC[v][63:32]);
      check("R9 pin_out vector", pin_out, VEC[v][31:0]);
      bus_read(12'h040, rd);
      check("R2/R3/R4 readback vector", rd, VEC[v][31:0]);
    end

    // direction and drive enable
    bus_write(12'h204, 32'h0000_FFFF);
    bus_write(12'h208, 32'h00FF_00FF);
    bus_read(12'h204, rd); check("R5 dir readback", rd, 32'h0000_FFFF);
    bus_read(12'h208, rd); check("R5 drive readback", rd, 32'h00FF_00FF);
    check("R6 pin_oe and", pin_oe, 32'h0000_00FF);
    bus_write(12'h208, 32'hFFFF_FFFF);
    check("R6 pin_oe dir only", pin_oe, 32'h0000_FFFF);

    // write-only and unmapped offsets read zero
    bus_read(12'h000, rd); check("R8 read lo port", rd, 32'h0);
    bus_read(12'h004, rd); check("R8 read hi port", rd, 32'h0);
    bus_read(12'h100, rd); check("R8 read unmapped", rd, 32'h0);

    // live pin latency
    @(negedge clk);
    bus_addr = 12'h060;
    pin_in = 32'h1357_9BDF;
    @(negedge clk);
    check("R7 after one edge", bus_rdata, 32'h0);
    @(negedge clk);
    check("R7 after two edges", bus_rdata, 32'h1357_9BDF);
    check("R9 pin_out unaffected by inputs", pin_out, 32'hAAAA_FAF4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule